// File: doc/BRIEF.md
# Two-Thread Shared Reorder Buffer

This block is the in-order retirement store for a core that runs two hardware threads at once. Both threads draw entries from one common pool. A dispatch request carries a thread number and an instruction tag. The block either returns the index of the entry it allocated or raises a stall in the same cycle. The execution side reports finished entries by index, and it can flag an entry as faulting. Each thread retires in its own program order. Each thread also keeps its own commit PC, which holds the tag of its most recently retired or faulting instruction.

A mode input sets how the pool is divided. In shared mode, either thread may take any number of free entries. In partitioned mode, each thread is held to half the pool while both threads are active, even when the other thread is using little of its half. A thread that runs alone may take the whole pool. When a thread's oldest entry faults, only that thread is flushed. The other thread's entries, order and commit PC stay as they were.

Top module: `rob_smt_top`

## Requirements
- R1: After reset the buffer is empty, nothing retires or faults, both commit PCs read 0 and the effective mode (`mode_o`, 0 = shared, 1 = partitioned) is 0.
- R2: A dispatch is accepted in the cycle it is presented unless it stalls. The allocated index is the lowest-numbered free entry. In shared mode one thread may fill all DEPTH entries, and the next request stalls.
- R3: In partitioned mode with only one thread marked active in `thr_active` (bit t = thread t), that thread may fill all DEPTH entries.
- R4: In partitioned mode with both threads active, a thread that already holds DEPTH/2 entries stalls. This holds even while the other thread holds fewer than DEPTH/2 entries and free entries remain.
- R5: In shared mode a request from either thread stalls once the two threads together hold DEPTH entries.
- R6: A thread retires only its oldest entry, and only once that entry is done. A younger done entry waits. At most one entry retires per cycle, and the thread's commit PC takes the retired tag.
- R7: When the oldest entries of both threads are ready in the same cycle, the thread that did not retire most recently wins. While both stay ready, the threads alternate.
- R8: When a thread's oldest entry is done and faulting, `exc_valid` is raised with `exc_tid` in place of a retirement. The commit PC of that thread takes the faulting tag, and all of that thread's entries are freed. A dispatch for that thread stalls in that cycle. The other thread's entries keep retiring in order.
- R9: `mode_req` is taken into the effective mode only in a cycle when the buffer holds no entries. At any other time it is ignored.
- R10: A completion aimed at an entry that holds no instruction has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req | input | 1 | Requested mode: 0 shared, 1 partitioned |
| thr_active | input | 2 | Bit t set when thread t is running |
| disp_valid | input | 1 | Dispatch request |
| disp_tid | input | 1 | Thread of the dispatch |
| disp_tag | input | TAGW | Instruction tag (its PC) |
| disp_stall | output | 1 | Request refused this cycle |
| disp_idx | output | log2(DEPTH) | Entry allocated to the request |
| cmpl_valid | input | 1 | Completion report |
| cmpl_idx | input | log2(DEPTH) | Entry that finished |
| cmpl_exc | input | 1 | The finished entry faulted |
| cmt_valid | output | 1 | An entry retires this cycle |
| cmt_tid | output | 1 | Thread of the retiring entry |
| cmt_tag | output | TAGW | Tag of the retiring entry |
| exc_valid | output | 1 | A thread faults and is flushed this cycle |
| exc_tid | output | 1 | Thread that faults |
| cpc0 | output | TAGW | Commit PC of thread 0 |
| cpc1 | output | TAGW | Commit PC of thread 1 |
| mode_o | output | 1 | Effective mode |

## Verification
The pool is filled by one thread in shared mode, by one thread alone in partitioned mode, by both threads under partitioning, and by a mixed split in shared mode. Comparing these runs separates the total-capacity stall from the per-thread cap, and shows that the cap depends on how many threads are active. Completions arrive oldest-first, youngest-first, and with the heads held back until last. These orders show that retirement waits on the oldest entry, and that two ready threads alternate. A fault injected while the other thread has work in flight shows that the flush stays inside one thread. Mode requests made while entries are held, and completions aimed at free entries, check that both are ignored.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Pick the retiring thread: the only ready one, or the one that lost last time.
  function automatic logic pick_thread(input logic [1:0] rdy, input logic last);
    if (rdy == 2'b11) return ~last;
    return rdy[1];
  endfunction

  // The half-pool cap is in force only when partitioned and both threads run.
  function automatic logic half_cap(input logic part, input logic [1:0] act);
    return part & act[0] & act[1];
  endfunction

endpackage

// File: rtl/rob_alloc.sv
module rob_alloc #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] busy,
  output logic [IW-1:0]    free_idx,
  output logic             any_free
);
  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        free_idx = IW'(i);
        any_free = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rob_order_q.sv
module rob_order_q #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [IW-1:0] push_idx,
  input  logic          pop,
  input  logic          clear,
  output logic [IW-1:0] head_idx,
  output logic [CW-1:0] count
);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [IW-1:0] slot [DEPTH];
  logic [IW-1:0] rd_q, wr_q;

  function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign head_idx = slot[rd_q];

  always_ff @(posedge clk) begin
    if (push) slot[wr_q] <= push_idx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      rd_q  <= '0;
      wr_q  <= '0;
      count <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
endmodule

// File: rtl/rob_smt_top.sv
module rob_smt_top #(
  parameter int DEPTH = 16,
  parameter int TAGW  = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_req,
  input  logic [1:0]      thr_active,
  input  logic            disp_valid,
  input  logic            disp_tid,
  input  logic [TAGW-1:0] disp_tag,
  output logic            disp_stall,
  output logic [IW-1:0]   disp_idx,
  input  logic            cmpl_valid,
  input  logic [IW-1:0]   cmpl_idx,
  input  logic            cmpl_exc,
  output logic            cmt_valid,
  output logic            cmt_tid,
  output logic [TAGW-1:0] cmt_tag,
  output logic            exc_valid,
  output logic            exc_tid,
  output logic [TAGW-1:0] cpc0,
  output logic [TAGW-1:0] cpc1,
  output logic            mode_o
);
  import rob_pkg::*;

  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  logic [DEPTH-1:0] ent_vld, ent_done, ent_exc, ent_tid;
  logic [TAGW-1:0]  ent_tag [DEPTH];
  logic             mode_q, last_q;
  logic [TAGW-1:0]  cpc_q [2];

  logic [IW-1:0] head_idx [2];
  logic [CW-1:0] cnt [2];
  logic [1:0]    ready, push, pop, flush;

  // Named internal events for the checks.
  logic          sel, retire_any, ret_exc, disp_fire, any_free;
  logic [IW-1:0] ret_idx, free_idx;
  logic [CW-1:0] limit;
  logic [CW:0]   total;

  rob_alloc #(.DEPTH(DEPTH)) u_alloc (
    .busy(ent_vld), .free_idx(free_idx), .any_free(any_free));

  for (genvar t = 0; t < 2; t++) begin : g_thr
    localparam logic TID = 1'(t);
    assign ready[t] = (cnt[t] != '0) && ent_done[head_idx[t]];
    assign push[t]  = disp_fire && (disp_tid == TID);
    assign pop[t]   = cmt_valid && (sel == TID);
    assign flush[t] = exc_valid && (sel == TID);

    rob_order_q #(.DEPTH(DEPTH)) u_order (
      .clk(clk), .rst_n(rst_n), .push(push[t]), .push_idx(free_idx),
      .pop(pop[t]), .clear(flush[t]), .head_idx(head_idx[t]), .count(cnt[t]));

    a_r8_flush_own: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && exc_tid == TID) |=> cnt[t] == '0);
    a_r8_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && exc_tid == TID) |=> cnt[1-t] >= $past(cnt[1-t]));
  end

  assign sel        = pick_thread(ready, last_q);
  assign retire_any = |ready;
  assign ret_idx    = head_idx[sel];
  assign ret_exc    = ent_exc[ret_idx];
  assign cmt_valid  = retire_any && !ret_exc;
  assign exc_valid  = retire_any && ret_exc;
  assign cmt_tid    = sel;
  assign exc_tid    = sel;
  assign cmt_tag    = ent_tag[ret_idx];

  assign total      = {1'b0, cnt[0]} + {1'b0, cnt[1]};
  assign limit      = half_cap(mode_q, thr_active) ? HALF : FULL;
  assign disp_fire  = disp_valid && any_free && (cnt[disp_tid] < limit) && !flush[disp_tid];
  assign disp_stall = disp_valid && !disp_fire;
  assign disp_idx   = free_idx;
  assign cpc0       = cpc_q[0];
  assign cpc1       = cpc_q[1];
  assign mode_o     = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld  <= '0;
      ent_done <= '0;
      ent_exc  <= '0;
      ent_tid  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (cmpl_valid && cmpl_idx == IW'(i) && ent_vld[i]) begin
          ent_done[i] <= 1'b1;
          ent_exc[i]  <= cmpl_exc;
        end
        if (cmt_valid && ret_idx == IW'(i)) ent_vld[i] <= 1'b0;
        if (exc_valid && ent_tid[i] == sel) ent_vld[i] <= 1'b0;
        if (disp_fire && free_idx == IW'(i)) begin
          ent_vld[i]  <= 1'b1;
          ent_done[i] <= 1'b0;
          ent_exc[i]  <= 1'b0;
          ent_tid[i]  <= disp_tid;
          ent_tag[i]  <= disp_tag;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      last_q   <= 1'b0;
      cpc_q[0] <= '0;
      cpc_q[1] <= '0;
    end else begin
      if (total == '0) mode_q <= mode_req;
      if (retire_any) begin
        last_q       <= sel;
        cpc_q[sel]   <= cmt_tag;
      end
    end
  end

  a_r1_total_bound: assert property (@(posedge clk) disable iff (!rst_n)
    total <= (CW+1)'(DEPTH));
  a_r4_half_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_fire && mode_q && thr_active == 2'b11) |=> cnt[$past(disp_tid)] <= HALF);
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (total != '0) |=> $stable(mode_q));
  a_r6_single_retire: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmt_valid, exc_valid}) && !(disp_fire && ent_vld[free_idx]));
endmodule

// File: tb/sim_rob_smt_top.sv
module sim_rob_smt_top;
  localparam int DEPTH = 16;
  localparam int TAGW  = 8;
  localparam int IW    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_req = 1'b0;
  logic [1:0] thr_active = 2'b11;
  logic disp_valid = 1'b0, disp_tid = 1'b0;
  logic [TAGW-1:0] disp_tag = '0;
  logic disp_stall;
  logic [IW-1:0] disp_idx;
  logic cmpl_valid = 1'b0, cmpl_exc = 1'b0;
  logic [IW-1:0] cmpl_idx = '0;
  logic cmt_valid, cmt_tid, exc_valid, exc_tid, mode_o;
  logic [TAGW-1:0] cmt_tag, cpc0, cpc1;

  int checks = 0, errors = 0;
  bit fin = 0;
  logic [9:0] expq [$];   // {fault, tid, tag}

  always #4 clk = ~clk;   // 125 MHz

  rob_smt_top #(.DEPTH(DEPTH), .TAGW(TAGW)) u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic disp(logic tid, logic [7:0] tag, logic exp_stall, logic [3:0] exp_idx, string req);
    @(negedge clk);
    disp_valid = 1'b1; disp_tid = tid; disp_tag = tag;
    #1;
    chk(req, 32'(disp_stall), 32'(exp_stall));
    if (!exp_stall) chk(req, 32'(disp_idx), 32'(exp_idx));
    @(posedge clk); #1;
    disp_valid = 1'b0;
  endtask

  task automatic cmpl(logic [3:0] idx, logic fault);
    @(negedge clk);
    cmpl_valid = 1'b1; cmpl_idx = idx; cmpl_exc = fault;
    @(posedge clk); #1;
    cmpl_valid = 1'b0; cmpl_exc = 1'b0;
  endtask

  task automatic expect_item(logic fault, logic tid, logic [7:0] tag);
    expq.push_back({fault, tid, tag});
  endtask

  // Scoreboard monitor: every retirement or fault is popped and compared.
  always @(negedge clk) begin
    #2;
    if (rst_n && (cmt_valid || exc_valid)) begin
      logic [9:0] got;
      got = {exc_valid, exc_valid ? exc_tid : cmt_tid, cmt_tag};
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6 unexpected retire actual %0h expected none", got);
      end else begin
        chk("R6/R7/R8 retire order", 32'(got), 32'(expq.pop_front()));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      errors++;
      $display("FAIL R1 watchdog actual timeout expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 cmt_valid", 32'(cmt_valid), 0);
    chk("R1 exc_valid", 32'(exc_valid), 0);
    chk("R1 cpc0", 32'(cpc0), 0);
    chk("R1 cpc1", 32'(cpc1), 0);
    chk("R1 mode", 32'(mode_o), 0);

    // R2: shared mode, one thread fills the pool, youngest-first completion.
    for (int i = 0; i < 16; i++) disp(1'b0, 8'(8'h10 + i), 1'b0, 4'(i), "R2 fill");
    disp(1'b0, 8'h20, 1'b1, 4'd0, "R2 full stall");
    for (int i = 15; i >= 1; i--) cmpl(4'(i), 1'b0);
    idle(2);
    chk("R6 head not done blocks", 32'(cmt_valid), 0);
    for (int i = 0; i < 16; i++) expect_item(1'b0, 1'b0, 8'(8'h10 + i));
    cmpl(4'd0, 1'b0);
    idle(20);
    chk("R6 cpc0 last retired", 32'(cpc0), 32'h1f);

    // R9: mode request ignored while entries are held.
    disp(1'b1, 8'h40, 1'b0, 4'd0, "R9 hold entry");
    mode_req = 1'b1;
    idle(3);
    chk("R9 mode ignored", 32'(mode_o), 0);
    expect_item(1'b0, 1'b1, 8'h40);
    cmpl(4'd0, 1'b0);
    idle(4);
    chk("R9 mode taken when empty", 32'(mode_o), 1);
    chk("R6 cpc1", 32'(cpc1), 32'h40);

    // R3: partitioned, thread 0 alone takes the whole pool.
    thr_active = 2'b01;
    for (int i = 0; i < 16; i++) disp(1'b0, 8'(8'h50 + i), 1'b0, 4'(i), "R3 alone fill");
    disp(1'b0, 8'h5f, 1'b1, 4'd0, "R3 full stall");
    for (int i = 0; i < 16; i++) expect_item(1'b0, 1'b0, 8'(8'h50 + i));
    for (int i = 0; i < 16; i++) cmpl(4'(i), 1'b0);
    idle(4);

    // R4: partitioned, both active; R7 alternation.
    thr_active = 2'b11;
    disp(1'b1, 8'h60, 1'b0, 4'd0, "R4 t1");
    disp(1'b1, 8'h61, 1'b0, 4'd1, "R4 t1");
    for (int i = 0; i < 8; i++) disp(1'b0, 8'(8'h70 + i), 1'b0, 4'(2 + i), "R4 t0 fill");
    disp(1'b0, 8'h78, 1'b1, 4'd0, "R4 cap stall with free entries");
    for (int i = 0; i < 6; i++) disp(1'b1, 8'(8'h62 + i), 1'b0, 4'(10 + i), "R4 t1 fill");
    disp(1'b1, 8'h68, 1'b1, 4'd0, "R4 t1 cap stall");
    cmpl(4'd1, 1'b0);
    for (int i = 3; i < 16; i++) cmpl(4'(i), 1'b0);
    idle(2);
    chk("R6 both heads pending", 32'(cmt_valid), 0);
    for (int i = 0; i < 8; i++) begin
      expect_item(1'b0, 1'b1, 8'(8'h60 + i));
      expect_item(1'b0, 1'b0, 8'(8'h70 + i));
    end
    cmpl(4'd0, 1'b0);
    cmpl(4'd2, 1'b0);
    idle(20);

    // R8: thread 0 faults while thread 1 has work in flight.
    for (int i = 0; i < 3; i++) disp(1'b0, 8'(8'h80 + i), 1'b0, 4'(i), "R8 t0");
    disp(1'b1, 8'h90, 1'b0, 4'd3, "R8 t1");
    disp(1'b1, 8'h91, 1'b0, 4'd4, "R8 t1");
    expect_item(1'b0, 1'b1, 8'h90);
    expect_item(1'b1, 1'b0, 8'h80);
    cmpl(4'd3, 1'b0);
    cmpl(4'd0, 1'b1);
    disp(1'b0, 8'h83, 1'b1, 4'd0, "R8 stall during flush");
    idle(1);
    chk("R8 cpc0 fault tag", 32'(cpc0), 32'h80);
    chk("R8 cpc1 untouched", 32'(cpc1), 32'h90);
    disp(1'b0, 8'h84, 1'b0, 4'd0, "R8 entries freed");
    expect_item(1'b0, 1'b1, 8'h91);
    expect_item(1'b0, 1'b0, 8'h84);
    cmpl(4'd4, 1'b0);
    cmpl(4'd0, 1'b0);
    idle(4);
    chk("R8 other thread retired", 32'(cpc1), 32'h91);

    // R10: completion to a free entry does nothing.
    cmpl(4'd6, 1'b1);
    idle(3);
    chk("R10 no retire", 32'(cmt_valid), 0);
    chk("R10 no fault", 32'(exc_valid), 0);
    disp(1'b0, 8'h85, 1'b0, 4'd0, "R10 lowest free");
    idle(3);
    chk("R10 new entry not done", 32'(cmt_valid), 0);
    expect_item(1'b0, 1'b0, 8'h85);
    cmpl(4'd0, 1'b0);
    idle(4);

    // R5: shared mode, mixed split fills the pool.
    mode_req = 1'b0;
    idle(3);
    chk("R9 back to shared", 32'(mode_o), 0);
    for (int i = 0; i < 10; i++) disp(1'b0, 8'(8'ha0 + i), 1'b0, 4'(i), "R5 t0");
    for (int i = 0; i < 6; i++) disp(1'b1, 8'(8'hb0 + i), 1'b0, 4'(10 + i), "R5 t1");
    disp(1'b1, 8'hb6, 1'b1, 4'd0, "R5 total stall t1");
    disp(1'b0, 8'haa, 1'b1, 4'd0, "R5 total stall t0");
    idle(2);
    chk("R6 scoreboard drained", 32'(expq.size()), 0);

    fin = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule